// File: doc/BRIEF.md
# Half-Integer Programmable Clock Divider

The block turns a fast timing tick into a slower divided clock. The tick runs at four times the rate of a 1x reference, so a divide ratio N gives an output period of 4×N ticks. A 3-bit select picks one of eight ratios, two of them half-integer (1.5 and 2.5). A mode input chooses between high-frequency behaviour, where the half-integer ratios come out with an asymmetric duty cycle, and low-frequency behaviour, where every ratio is 50/50.

A lock input qualifies the output. While lock is low the divided clock and its strobe are held low. When lock returns, a fresh, full-length period starts at once. The divider loads a new select or mode only where a period begins, so a change made in the middle of a period never cuts a pulse short. A one-tick strobe marks the first tick of every output period.

Top module: `clkdiv_frac`

## Requirements
- R1: The output period in ticks is 4×N for select codes 0..7 mapping to N = 1.5, 2, 2.5, 3, 4, 5, 8, 16, that is 6, 8, 10, 12, 16, 20, 32, 64 ticks.
- R2: For the integer ratios (codes 1, 3, 4, 5, 6, 7) the output is high for 2×N ticks and low for 2×N ticks in either mode.
- R3: With the mode input at 1 (high-frequency), code 0 gives 2 ticks high and 4 low, and code 2 gives 4 ticks high and 6 low.
- R4: With the mode input at 0 (low-frequency), code 0 gives 3 ticks high and 3 low, and code 2 gives 5 ticks high and 5 low.
- R5: On every tick that follows a tick where lock was sampled low, both the divided clock and the strobe are low.
- R6: The strobe is high for exactly one tick at the start of each period, on the same tick that the divided clock rises.
- R7: A change of select or mode made inside a period leaves that period unchanged and takes effect from the next period start.
- R8: On the tick after lock is first sampled high following a low, a period starts (strobe high) and that first period has full length.
- R9: During reset and afterwards until lock is high, both outputs are low; the stored ratio resets to code 1 (divide by 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timing tick, four times the 1x reference rate |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_sel_i | input | 3 | Divide ratio code, 0..7 ascending 1.5 to 16 |
| hf_mode_i | input | 1 | 1 = high-frequency duty rule, 0 = 50/50 everywhere |
| lock_i | input | 1 | Output qualifier; outputs held low while 0 |
| div_clk_o | output | 1 | Divided clock |
| period_start_o | output | 1 | One-tick strobe at each period start |

## Verification
Every select code is measured in both modes, which separates the half-integer codes, whose high time depends on the mode, from the integer codes, whose high time must not. A mid-period switch from the longest ratio to the shortest tells a divider that reloads at the boundary from one that reloads at once. Dropping and restoring lock in mid-period shows that the output is forced low and that the restart yields a full period, not the tail of the old one. A behavioural model runs alongside the whole sequence and is compared on every tick.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int SEL_W = 3;
    localparam int CNT_W = 7;
    localparam logic [SEL_W-1:0] RESET_CODE = 3'd1;

    typedef logic [SEL_W-1:0] ratio_code_t;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
    } div_cfg_t;

    // twice the ratio: 3,4,5,6,8,10,16,32
    function automatic logic [CNT_W-1:0] twice_ratio(input ratio_code_t code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd0:    r = 7'd3;
            3'd1:    r = 7'd4;
            3'd2:    r = 7'd5;
            3'd3:    r = 7'd6;
            3'd4:    r = 7'd8;
            3'd5:    r = 7'd10;
            3'd6:    r = 7'd16;
            default: r = 7'd32;
        endcase
        return r;
    endfunction

    function automatic div_cfg_t decode_cfg(input ratio_code_t code, input logic hf);
        div_cfg_t c;
        logic [CNT_W-1:0] n2;
        n2       = twice_ratio(code);
        c.period = n2 << 1;
        // odd twice-ratio means half-integer ratio
        c.high   = (hf && n2[0]) ? (n2 - 7'd1) : n2;
        return c;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_decode.sv
module clkdiv_cfg_decode
    import clkdiv_pkg::*;
(
    input  ratio_code_t sel_i,
    input  logic        hf_i,
    output div_cfg_t    cfg_o
);
    always_comb begin
        cfg_o = decode_cfg(sel_i, hf_i);
    end
endmodule

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr
    import clkdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         lock_i,
    input  div_cfg_t     cfg_next_i,
    output logic         start_o,
    output logic [W-1:0] cnt_o,
    output div_cfg_t     cfg_o
);
    logic         run_q;
    logic [W-1:0] cnt_q;
    div_cfg_t     cfg_q;
    logic         last_w;

    assign last_w  = (cnt_q == cfg_q.period - 1'b1);
    assign start_o = lock_i && (!run_q || last_w);
    assign cnt_o   = cnt_q;
    assign cfg_o   = cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            cfg_q <= decode_cfg(RESET_CODE, 1'b0);
        end else if (!lock_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_o) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            cfg_q <= cfg_next_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
    import clkdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         lock_i,
    input  logic         start_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] high_i,
    output logic         div_clk_o,
    output logic         strobe_o
);
    logic [W:0] next_cnt;
    assign next_cnt = {1'b0, cnt_i} + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i || !lock_i) begin
            div_clk_o <= 1'b0;
            strobe_o  <= 1'b0;
        end else if (start_i) begin
            div_clk_o <= 1'b1;
            strobe_o  <= 1'b1;
        end else begin
            div_clk_o <= (next_cnt < {1'b0, high_i});
            strobe_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/clkdiv_frac.sv
module clkdiv_frac
    import clkdiv_pkg::*;
#(
    parameter int SELW = SEL_W,
    parameter int CW   = CNT_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [SELW-1:0] ratio_sel_i,
    input  logic            hf_mode_i,
    input  logic            lock_i,
    output logic            div_clk_o,
    output logic            period_start_o
);
    div_cfg_t        cfg_next;
    div_cfg_t        cfg_q;
    logic            start_w;
    logic [CW-1:0]   cnt_q;

    clkdiv_cfg_decode u_dec (
        .sel_i (ratio_sel_i),
        .hf_i  (hf_mode_i),
        .cfg_o (cfg_next)
    );

    clkdiv_period_ctr #(.W(CW)) u_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .lock_i     (lock_i),
        .cfg_next_i (cfg_next),
        .start_o    (start_w),
        .cnt_o      (cnt_q),
        .cfg_o      (cfg_q)
    );

    clkdiv_out_stage #(.W(CW)) u_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .lock_i    (lock_i),
        .start_i   (start_w),
        .cnt_i     (cnt_q),
        .high_i    (cfg_q.high),
        .div_clk_o (div_clk_o),
        .strobe_o  (period_start_o)
    );
endmodule

// File: rtl/clkdiv_frac_chk.sv
module clkdiv_frac_chk #(
    parameter int CW = 7
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          lock_i,
    input logic          div_clk_o,
    input logic          period_start_o,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] cur_period,
    input logic [CW-1:0] cur_high
);
    AST_LOCK_LOW_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(lock_i) |-> (!div_clk_o && !period_start_o)); // R5

    AST_STROBE_WITH_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        period_start_o |-> div_clk_o); // R6

    AST_RISE_HAS_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(div_clk_o) |-> period_start_o); // R6

    AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !period_start_o |-> ($stable(cur_period) && $stable(cur_high))); // R7

    AST_LOCK_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_i && !$past(lock_i)) |=> period_start_o); // R8

    AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < cur_period); // R1
endmodule

bind clkdiv_frac clkdiv_frac_chk #(.CW(CW)) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .lock_i         (lock_i),
    .div_clk_o      (div_clk_o),
    .period_start_o (period_start_o),
    .cnt_q          (cnt_q),
    .cur_period     (cfg_q.period),
    .cur_high       (cfg_q.high)
);

// File: tb/test_clkdiv_frac.sv
`timescale 1ns/1ps
module test_clkdiv_frac;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd1;
    logic       hf  = 1'b0;
    logic       lock = 1'b0;
    logic       dclk, stb;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R9";

    always #2.5 clk = ~clk;

    clkdiv_frac i_clkdiv_frac (
        .clk_i(clk), .rst_i(rst), .ratio_sel_i(sel), .hf_mode_i(hf),
        .lock_i(lock), .div_clk_o(dclk), .period_start_o(stb)
    );

    // expectations straight from the requirements
    function automatic int exp_period(input int code);
        int half2[8] = '{3, 4, 5, 6, 8, 10, 16, 32};
        return 2 * half2[code];
    endfunction
    function automatic int exp_high(input int code, input bit mode_hf);
        if (mode_hf && code == 0) return 2;
        if (mode_hf && code == 2) return 4;
        return exp_period(code) / 2;
    endfunction

    // behavioural reference, updated each tick
    int m_cnt = 0, m_per = 8, m_hi = 4;
    bit m_run = 0, m_out = 0, m_stb = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_out = 0; m_stb = 0; m_cnt = 0;
            m_per = exp_period(1); m_hi = exp_high(1, 0);
        end else if (!lock) begin
            m_run = 0; m_out = 0; m_stb = 0; m_cnt = 0;
        end else if (!m_run || m_cnt == m_per - 1) begin
            m_per = exp_period(sel); m_hi = exp_high(sel, hf);
            m_cnt = 0; m_run = 1; m_out = 1; m_stb = 1;
        end else begin
            m_cnt++; m_out = (m_cnt < m_hi); m_stb = 0;
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (dclk !== m_out || stb !== m_stb) begin
            n_bad++;
            $display("FAIL %s tick compare: out=%b stb=%b expected out=%b stb=%b",
                     phase, dclk, stb, m_out, m_stb);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (stb !== 1'b1);
    endtask

    // measure one period starting at a strobe
    task automatic measure(output int hi, output int lo);
        hi = 1; lo = 0;
        forever begin
            @(negedge clk);
            if (stb === 1'b1) break;
            if (dclk === 1'b1) hi++; else lo++;
        end
    endtask

    task automatic try_ratio(input int code, input bit mode_hf);
        int hi, lo;
        string req;
        @(negedge clk); #1;
        sel = code[2:0]; hf = mode_hf;
        wait_strobe();
        measure(hi, lo);
        if (code == 0 || code == 2) req = mode_hf ? "R3" : "R4";
        else req = "R2";
        phase = req;
        check("R1", $sformatf("period code %0d hf %0d", code, mode_hf), hi + lo, exp_period(code));
        check(req, $sformatf("high code %0d hf %0d", code, mode_hf), hi, exp_high(code, mode_hf));
        check(req, $sformatf("low code %0d hf %0d", code, mode_hf), lo, exp_period(code) - exp_high(code, mode_hf));
    endtask

    initial begin
        int hi, lo, n;
        // reset state
        repeat (3) @(negedge clk);
        check("R9", "out in reset", dclk, 0);
        check("R9", "strobe in reset", stb, 0);
        #1 rst = 1'b0;
        repeat (4) tick();
        check("R9", "out after reset unlocked", dclk, 0);
        check("R9", "strobe after reset unlocked", stb, 0);

        // lock: first period, reset ratio code 1
        lock = 1'b1;
        phase = "R8";
        @(negedge clk);
        check("R8", "strobe tick after lock", stb, 1);
        measure(hi, lo);
        check("R8", "first period length", hi + lo, 8);

        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 8; c++)
                try_ratio(c, m[0]);

        // mid-period change
        phase = "R7";
        #1 sel = 3'd7; hf = 1'b1;
        wait_strobe();
        repeat (3) @(negedge clk);
        #1 sel = 3'd0;
        n = 3;
        do begin @(negedge clk); n++; end while (stb !== 1'b1);
        check("R7", "period after mid change", n, 64);
        measure(hi, lo);
        check("R7", "next period uses new code", hi + lo, 6);

        // lock drop mid-period
        phase = "R5";
        #1 sel = 3'd6; hf = 1'b0;
        wait_strobe();
        repeat (5) @(negedge clk);
        #1 lock = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            check("R5", "out with lock low", dclk, 0);
            check("R5", "strobe with lock low", stb, 0);
            @(negedge clk);
        end
        #1 lock = 1'b1;
        phase = "R8";
        @(negedge clk);
        check("R8", "strobe after relock", stb, 1);
        check("R6", "out rises with strobe", dclk, 1);
        measure(hi, lo);
        check("R8", "full period after relock", hi + lo, 32);
        check("R6", "high after relock", hi, 16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule